// File: doc/BRIEF.md
# Dependent-Read Latency Probe

The probe measures how long a memory takes to answer a read when every read depends on the one before it. Software or a test harness writes a start address and a hop count and pulses start. The probe sends a read to the start address. When the data comes back, the probe uses the low address bits of that data as the address of the next read, and it continues this way for the programmed number of hops. Only one read is ever in flight. Because of this, the elapsed cycle count divided by the hop count gives the amortised read latency directly.

The memory holds a pointer chain whose links are placed far apart, so that every access goes to the backing store. Loading that chain into memory is done elsewhere. The probe has a read-request channel and a read-response channel, each using a valid/ready handshake. It reports the number of completed hops, the cycle total and a done flag. These results stay in place until the next run is started.

Top module: `chase_probe`

## Requirements
- R1: Immediately after reset, done_o, req_valid_o and rsp_ready_o are all low, and hops_o and cycles_o are both zero.
- R2: A start pulse accepted while idle or finished loads the start address and the hop count. When the hop count is non-zero, the first request appears on the next cycle with req_addr_o equal to the start address.
- R3: Every request after the first carries the low ADDR_W bits of the data returned by the previous response. Any upper data bits are discarded.
- R4: The probe has at most one read in flight. From the cycle a request is accepted until its response is taken, req_valid_o is low and rsp_ready_o is high. rsp_ready_o is low at all other times.
- R5: A request that is not yet accepted keeps req_valid_o high and req_addr_o unchanged.
- R6: hops_o increases by one for each response taken. When the run finishes, it equals the programmed hop count.
- R7: cycles_o counts the clock edges after the edge that accepts the first request, up to and including the edge that takes the final response. With L idle response cycles per hop and G stalled request cycles per later hop, a run of N hops therefore totals N*(L+1)+(N-1)*(G+1).
- R8: A hop count of zero raises done_o on the cycle after the start pulse, with hops_o and cycles_o both zero and no request issued.
- R9: Once done_o is high, it stays high, and hops_o and cycles_o hold their values until the next start pulse. Responses presented in this period have no effect.
- R10: A start pulse while done_o is high clears done_o, resets both counts and begins a new run.
- R11: A start pulse during a run is ignored, and the chain of addresses continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted when idle or finished |
| start_addr_i | input | ADDR_W | Address of the first read |
| hop_count_i | input | HOP_W | Number of dependent reads to perform |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ADDR_W | Read address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_ready_o | output | 1 | Probe is waiting for read data |
| rsp_data_i | input | DATA_W | Read data; its low bits form the next address |
| hops_o | output | HOP_W | Completed hops |
| cycles_o | output | CNT_W | Elapsed cycles of the run |
| done_o | output | 1 | Run finished; results are valid |

## Verification
Each output is registered once after the event that changes it. The first request appears one edge after start, and the zero-hop done one edge after start. Once a response is taken, the next request or done_o is seen one edge later, and the cycle total is final on that same edge. The bench drives inputs on falling edges and samples on the falling edge that follows each rising edge. It computes the expected cycle total from the stall and latency counts it applied itself, using the formula in R7.

// File: rtl/chase_pkg.sv
// Shared types for the dependent-read latency probe.
package chase_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } probe_state_e;
endpackage

// File: rtl/chase_ctrl.sv
// Sequencer for the pointer chain. It tracks the remaining hops and steps
// through idle, issue, wait and done. Assumes start_i is ignored except in
// the idle and done states.
module chase_ctrl
    import chase_pkg::*;
#(
    parameter int HOP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [HOP_W-1:0] hop_count_i,
    input  logic             req_ready_i,
    input  logic             rsp_valid_i,
    output probe_state_e     state_o,
    output logic             load_o,
    output logic             take_o
);
    probe_state_e     state_q, state_d;
    logic [HOP_W-1:0] remain_q;
    logic             accept;

    // Decode the handshake events for the current state.
    always_comb begin
        load_o = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;
        accept = (state_q == ST_ISSUE) && req_ready_i;
        take_o = (state_q == ST_WAIT) && rsp_valid_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (load_o) begin
            state_d = (hop_count_i == '0) ? ST_DONE : ST_ISSUE;
        end else if (accept) begin
            state_d = ST_WAIT;
        end else if (take_o) begin
            state_d = (remain_q == HOP_W'(1)) ? ST_DONE : ST_ISSUE;
        end
    end

    // State register and remaining-hop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                remain_q <= hop_count_i;
            end else if (take_o) begin
                remain_q <= remain_q - HOP_W'(1);
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/chase_addr.sv
// Address register for the chain. It loads the start address and then
// takes each next address from the returned data, truncating the data or
// zero-extending it to ADDR_W.
module chase_addr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] addr_q;

    generate
        if (DATA_W >= ADDR_W) begin : g_trunc
            // Keep only the low address bits of the data.
            assign link_addr = rsp_data_i[ADDR_W-1:0];
        end else begin : g_extend
            // Data narrower than an address: pad with zeros.
            assign link_addr = {{(ADDR_W-DATA_W){1'b0}}, rsp_data_i};
        end
    endgenerate

    // Hold the address of the outstanding or next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= start_addr_i;
        end else if (take_i) begin
            addr_q <= link_addr;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/chase_tally.sv
// Hop and cycle counters. The cycle counter runs from the edge after the
// first acceptance through the final response edge. Assumes the sequencer
// cannot revisit issue once the run is over.
module chase_tally
    import chase_pkg::*;
#(
    parameter int HOP_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  probe_state_e     state_i,
    input  logic             load_i,
    input  logic             take_i,
    output logic [HOP_W-1:0] hops_o,
    output logic [CNT_W-1:0] cycles_o
);
    logic [HOP_W-1:0] hops_q;
    logic [CNT_W-1:0] cycles_q;
    logic             timing;

    // The clock is running while a read is in flight, or while a later read waits to be issued.
    always_comb begin
        timing = (state_i == ST_WAIT) || ((state_i == ST_ISSUE) && (hops_q != '0));
    end

    // Count completed hops and elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hops_q   <= '0;
            cycles_q <= '0;
        end else if (load_i) begin
            hops_q   <= '0;
            cycles_q <= '0;
        end else begin
            if (take_i) begin
                hops_q <= hops_q + HOP_W'(1);
            end
            if (timing) begin
                cycles_q <= cycles_q + CNT_W'(1);
            end
        end
    end

    assign hops_o   = hops_q;
    assign cycles_o = cycles_q;
endmodule

// File: rtl/chase_probe.sv
// Top of the dependent-read latency probe. It sends a chain of reads, each
// addressed by the data returned from the one before, and keeps one read in
// flight at a time. Assumes the memory never returns a response that was
// not requested.
module chase_probe
    import chase_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int HOP_W  = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [HOP_W-1:0]  hop_count_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic [HOP_W-1:0]  hops_o,
    output logic [CNT_W-1:0]  cycles_o,
    output logic              done_o
);
    probe_state_e state;
    logic         load;
    logic         take;

    chase_ctrl #(.HOP_W(HOP_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .hop_count_i (hop_count_i),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .state_o     (state),
        .load_o      (load),
        .take_o      (take)
    );

    chase_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .take_i       (take),
        .start_addr_i (start_addr_i),
        .rsp_data_i   (rsp_data_i),
        .addr_o       (req_addr_o)
    );

    chase_tally #(.HOP_W(HOP_W), .CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .load_i   (load),
        .take_i   (take),
        .hops_o   (hops_o),
        .cycles_o (cycles_o)
    );

    // Decode the port flags from the sequencer state.
    always_comb begin
        req_valid_o = (state == ST_ISSUE);
        rsp_ready_o = (state == ST_WAIT);
        done_o      = (state == ST_DONE);
    end
endmodule

// File: rtl/chase_probe_chk.sv
// Protocol and result checks for chase_probe. They are attached to the probe by bind.
module chase_probe_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int HOP_W  = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic              rsp_valid_i,
    input logic              rsp_ready_o,
    input logic [DATA_W-1:0] rsp_data_i,
    input logic [HOP_W-1:0]  hops_o,
    input logic [CNT_W-1:0]  cycles_o,
    input logic              done_o
);
    // R4: never waiting for data while a request is offered
    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> !rsp_ready_o);

    // R4: an accepted request is followed by waiting for its response
    a_r4_wait_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (rsp_ready_o && !req_valid_o));

    // R5: an unaccepted request holds
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

    // R3: the next address follows from the returned data
    a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_ready_o) |=>
            (!req_valid_o || (req_addr_o == $past(rsp_data_i[ADDR_W-1:0]))));

    // R6: every taken response adds one hop
    a_r6_hop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_ready_o && !start_i) |=> (hops_o == $past(hops_o) + HOP_W'(1)));

    // R9: finished results hold until a new start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(hops_o) && $stable(cycles_o)));

    // R1: flags are mutually exclusive
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid_o, rsp_ready_o, done_o}));
endmodule

bind chase_probe chase_probe_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOP_W(HOP_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_data_i  (rsp_data_i),
    .hops_o      (hops_o),
    .cycles_o    (cycles_o),
    .done_o      (done_o)
);

// File: tb/chase_probe_bench.sv
// Directed bench for chase_probe. Each task runs one scenario and checks its own results.
module chase_probe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int HOP_W  = 32;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [HOP_W-1:0]  hop_count_i = '0;
    logic              req_valid_o;
    logic              req_ready_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_o;
    logic              rsp_valid_i = 1'b0;
    logic              rsp_ready_o;
    logic [DATA_W-1:0] rsp_data_i = '0;
    logic [HOP_W-1:0]  hops_o;
    logic [CNT_W-1:0]  cycles_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    chase_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOP_W(HOP_W), .CNT_W(CNT_W)) u_chase_probe (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .hop_count_i(hop_count_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
        .rsp_data_i(rsp_data_i), .hops_o(hops_o), .cycles_o(cycles_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Chain contents: the low word is a far-away next address, the high word is noise.
    function automatic logic [DATA_W-1:0] link_of(input logic [ADDR_W-1:0] a);
        return {a ^ 32'hC3C3_0000, a + 32'h0010_0400};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [ADDR_W-1:0] a, input logic [HOP_W-1:0] n);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; hop_count_i = n;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs one chain of n hops with lat idle response cycles and gap request stalls.
    task automatic run_chain(input logic [ADDR_W-1:0] a, input int n, input int lat,
                             input int gap, input bit poke);
        logic [ADDR_W-1:0] exp_addr;
        int exp_cycles;
        pulse_start(a, HOP_W'(n));
        if (n == 0) begin
            check("R8 done", 64'(done_o), 64'd1);
            check("R8 cycles", 64'(cycles_o), 64'd0);
            check("R8 hops", 64'(hops_o), 64'd0);
            check("R8 no request", 64'(req_valid_o), 64'd0);
            return;
        end
        check("R10 done cleared", 64'(done_o), 64'd0);
        exp_addr = a;
        for (int h = 0; h < n; h++) begin
            check("R2 R3 request valid", 64'(req_valid_o), 64'd1);
            check(h == 0 ? "R2 first addr" : "R3 next addr", 64'(req_addr_o), 64'(exp_addr));
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                @(negedge clk);
                check("R5 held", {31'd0, req_valid_o, req_addr_o}, {31'd0, 1'b1, exp_addr});
            end
            req_ready_i = 1'b1;
            if (poke) begin
                start_i = 1'b1; start_addr_i = 32'h0BAD_0000; hop_count_i = 32'd1;
            end
            @(posedge clk);
            @(negedge clk);
            req_ready_i = 1'b0;
            start_i = 1'b0;
            check("R4 one outstanding", {62'd0, req_valid_o, rsp_ready_o}, 64'd1);
            for (int l = 0; l < lat; l++) begin
                @(posedge clk);
                @(negedge clk);
            end
            rsp_valid_i = 1'b1;
            rsp_data_i = link_of(exp_addr);
            if (poke) start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rsp_valid_i = 1'b0;
            start_i = 1'b0;
            exp_addr = exp_addr + 32'h0010_0400;
        end
        exp_cycles = n * (lat + 1) + (n - 1) * (gap + 1);
        check("R6 done", 64'(done_o), 64'd1);
        check("R6 hops", 64'(hops_o), 64'(n));
        check("R7 cycles", 64'(cycles_o), 64'(exp_cycles));
    endtask

    task automatic test_reset();
        check("R1 done", 64'(done_o), 64'd0);
        check("R1 req_valid", 64'(req_valid_o), 64'd0);
        check("R1 rsp_ready", 64'(rsp_ready_o), 64'd0);
        check("R1 counts", {hops_o, cycles_o}, 64'd0);
    endtask

    // R9: results hold, and stray responses are ignored once done.
    task automatic test_hold(input int n, input int cyc);
        for (int k = 0; k < 5; k++) begin
            rsp_valid_i = 1'b1; rsp_data_i = 64'hFFFF_FFFF_1234_5678; req_ready_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check("R9 done held", {62'd0, done_o, req_valid_o}, 64'd2);
            check("R9 hops held", 64'(hops_o), 64'(n));
            check("R9 cycles held", 64'(cycles_o), 64'(cyc));
        end
        rsp_valid_i = 1'b0; req_ready_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_chain(32'h0000_1000, 0, 0, 0, 1'b0);       // R8 from idle
        run_chain(32'h0000_2000, 1, 0, 0, 1'b0);       // R7 minimum: one cycle
        run_chain(32'h0004_0000, 5, 3, 1, 1'b0);       // R3 R5 R7
        test_hold(5, 5 * 4 + 4 * 2);                    // R9
        run_chain(32'h8000_0040, 8, 7, 0, 1'b1);       // R11 start pokes ignored, R10 restart
        run_chain(32'h0000_3000, 3, 0, 2, 1'b0);       // R10 restart from done
        run_chain(32'h0000_4000, 0, 0, 0, 1'b0);       // R8 from done
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule